// File: doc/BRIEF.md
# Block-Write Configuration Register Target

This block is a two-wire serial target that holds thirteen byte-wide configuration registers. A host reaches the registers only as a block, never by offset. A write names the target, sends two bytes that the block acknowledges and then throws away, and then sends data bytes that land in register 0, 1, 2 and so on until the STOP condition. A read names the target with the read bit set, and the block then returns register 0, 1, 2 and so on, with no command byte first. Every transfer starts again at register 0.

The registers appear in parallel on `cfg_o`, one byte per register, so the clock-generation logic around the block can decode them directly. Two registers hold fixed identity values. Register 4 carries five strap inputs, which are captured once on the first clock after reset, above three writable enable bits. Register 6 carries a live status flag in bit 6. The serial lines pass through two-flop synchronisers. SDA is driven only as an open-drain pull-down enable.

The block has no streaming data path, so there is no valid/ready pair at its edge. The serial bus gives no back-pressure, and the parallel outputs are level signals.

Top module: `cfg_blk_i2c_target`

## Requirements
- R1: After reset the register view (index: value) is 0:0x00, 1:0xCF, 2:0xFF, 3:0xFF, 4:{straps,3'b111}, 5:0x93, 6:{0,flag,000000}, 7:0x40, 8 to 10:0x00, 11:0x05, 12:0x21.
- R2: An address byte whose upper seven bits differ from `TARGET_ADDR` gets no acknowledge (SDA stays released). The block then ignores, and does not acknowledge, every byte up to the next START or STOP, and no register changes.
- R3: In a write (R/W bit 0 = 0), the first two bytes after the address are acknowledged and written nowhere. A write that ends after those two bytes changes nothing.
- R4: The data bytes of a write go to register 0, 1, 2, ... in order, and each one is acknowledged. A byte's new value appears on `cfg_o` within the SCL-low phase that follows its eighth bit.
- R5: A read (R/W bit 0 = 1) returns register 0, 1, 2, ..., MSB first. It goes on while the host acknowledges, and a host NACK ends the stream.
- R6: Write data past register 12 is acknowledged and discarded. Read data past register 12 is 0xFF.
- R7: Registers 11 and 12 always read 0x05 and 0x21, and writes to them have no effect.
- R8: Register 4 bits 7:3 hold `strap_i[4:0]` as sampled on the first clock after reset, and later strap changes or writes do not alter them. Bits 2:0 are writable.
- R9: Register 6 bit 6 shows `stat_flag_i` delayed by one clock and ignores writes. The other bits of register 6 are writable.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 5 | Strap levels captured once after reset |
| stat_flag_i | input | 1 | Status flag shown in register 6 bit 6 |
| cfg_o | output | 104 | Register view, register k in bits 8k+7:8k |

## Verification
If the byte pointer, the header counter or the address decision goes wrong, the error shows on `cfg_o` in the same SCL-low phase where a write byte lands. A byte appears in the wrong register, a header byte gets written, or a rejected transfer alters state. The bench compares the whole register view against its own model on every clock, so such an error is caught within a few clocks of the bit that causes it. A wrong read pointer or a wrong shift order shows up as a wrong data bit at the very next SCL-high sample. A lost acknowledge shows up in the ninth clock of the affected byte.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int NREG    = 13;
  localparam int NSTORE  = NREG - 2;
  localparam int IDX_W   = $clog2(NREG + 1);
  localparam int STRAP_W = 5;
  localparam logic [7:0] ID_LO = 8'h05;
  localparam logic [7:0] ID_HI = 8'h21;
  localparam logic [7:0] PAST_END = 8'hFF;

  typedef enum logic [2:0] {
    EN_IDLE, EN_ADDR, EN_AACK, EN_WBYTE, EN_WACK, EN_RBYTE, EN_RACK, EN_SKIP
  } eng_st_t;

  function automatic logic [7:0] rst_byte(input int idx);
    case (idx)
      1:       return 8'hCF;
      2, 3:    return 8'hFF;
      4:       return 8'h07;
      5:       return 8'h93;
      7:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      4:       return 8'h07;
      6:       return 8'hBF;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cbt_line_sync.sv
module cbt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cbt_byte_engine.sv
module cbt_byte_engine
  import cbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG);

  eng_st_t          st;
  logic [7:0]       sh;
  logic [3:0]       cnt;
  logic [1:0]       hdr;
  logic [IDX_W-1:0] ptr;
  logic             rw;

  assign rd_idx = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= EN_IDLE; sh <= '0; cnt <= '0; hdr <= '0; ptr <= '0; rw <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st <= EN_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st <= EN_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          EN_ADDR, EN_WBYTE: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == EN_ADDR) begin
                if (sh[7:1] == TARGET_ADDR) begin
                  st <= EN_AACK; sda_oe <= 1'b1; rw <= sh[0];
                  ptr <= '0; hdr <= '0;
                end else begin
                  st <= EN_SKIP;
                end
              end else begin
                st <= EN_WACK;
                sda_oe <= 1'b1;
                if (hdr == 2'd2) begin
                  wr_en <= 1'b1; wr_idx <= ptr; wr_data <= sh;
                  if (ptr != LAST) ptr <= ptr + 1'b1;
                end else begin
                  hdr <= hdr + 2'd1;
                end
              end
            end
          end
          EN_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= EN_RBYTE; sh <= rd_data; sda_oe <= ~rd_data[7];
            end else begin
              st <= EN_WBYTE; sda_oe <= 1'b0;
            end
          end
          EN_WACK: if (scl_fall) begin
            st <= EN_WBYTE; sda_oe <= 1'b0; cnt <= '0;
          end
          EN_RBYTE: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= EN_RACK;
            end else begin
              cnt <= cnt + 4'd1;
              sh <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          EN_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= EN_SKIP;
              else if (ptr != LAST) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              st <= EN_RBYTE; cnt <= '0; sh <= rd_data; sda_oe <= ~rd_data[7];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cbt_reg_bank.sv
module cbt_reg_bank
  import cbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               stat_flag_i,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  view_o
);
  logic [7:0]         stor [NSTORE];
  logic [7:0]         view [NREG];
  logic [STRAP_W-1:0] strap_q;
  logic               strap_done;
  logic               flag_q;

  always_ff @(posedge clk) flag_q <= stat_flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q <= strap_i;
      strap_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam logic [7:0] RV = rst_byte(g);
    localparam logic [7:0] WM = wr_mask(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stor[g] <= RV;
      else if (wr_en && wr_idx == IDX_W'(g))
        stor[g] <= (stor[g] & ~WM) | (wr_data & WM);
    end
  end

  always_comb begin
    for (int i = 0; i < NSTORE; i++) view[i] = stor[i];
    view[4]  = {strap_q, stor[4][2:0]};
    view[6]  = {stor[6][7], flag_q, stor[6][5:0]};
    view[11] = ID_LO;
    view[12] = ID_HI;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign view_o[g*8 +: 8] = view[g];
  end

  always_comb begin
    rd_data = PAST_END;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = view[i];
  end
endmodule

// File: rtl/cfg_blk_i2c_target.sv
module cfg_blk_i2c_target
  import cbt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               stat_flag_i,
  output logic [NREG*8-1:0]  cfg_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  cbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cbt_byte_engine #(.TARGET_ADDR(TARGET_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  cbt_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .stat_flag_i(stat_flag_i),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .view_o(cfg_o)
  );
endmodule

// File: rtl/cfg_blk_i2c_target_chk.sv
module cfg_blk_i2c_target_chk
  import cbt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic              stat_flag_i,
  input logic [NREG*8-1:0] cfg_o
);
  logic [1:0] age;
  logic [NREG*8-1:0] wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    wmask = '1;
    wmask[4*8+3 +: 5] = '0;
    wmask[6*8+6] = 1'b0;
  end

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R10
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> $stable(cfg_o[4*8+3 +: 5])); // R8
  AST_WRITE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o & wmask) |-> !scl_i); // R4
  AST_FLAG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cfg_o[6*8+6] == $past(stat_flag_i)); // R9
endmodule

bind cfg_blk_i2c_target cfg_blk_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .stat_flag_i(stat_flag_i), .cfg_o(cfg_o)
);

// File: tb/cfg_blk_i2c_target_tb.sv
module cfg_blk_i2c_target_tb;
  localparam int Q = 8;
  localparam logic [6:0] ADR = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic flag = 1'b0;
  logic sda_oe;
  logic [103:0] cfg;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  cfg_blk_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .stat_flag_i(flag), .cfg_o(cfg)
  );

  int n_cmp = 0, n_bad = 0;
  bit settle = 1'b1, done = 1'b0;
  logic [7:0] m [13];
  logic [4:0] strap_lat;
  logic flag_d = 1'b0;

  function automatic logic [7:0] mview(int i);
    if (i == 4) return {strap_lat, m[4][2:0]};
    if (i == 6) return {m[6][7], flag_d, m[6][5:0]};
    if (i == 11) return 8'h05;
    if (i == 12) return 8'h21;
    if (i > 12) return 8'hFF;
    return m[i];
  endfunction

  function automatic void mwrite(int i, logic [7:0] d);
    logic [7:0] k;
    if (i > 10) return;
    k = (i == 4) ? 8'h07 : (i == 6) ? 8'hBF : 8'hFF;
    m[i] = (m[i] & ~k) | (d & k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the whole register view (R1 R4 R7 R8 R9)
  always @(posedge clk) begin
    #3;
    if (rst_n && !settle && !done)
      for (int i = 0; i < 13; i++) chk("R4_view", {24'd0, cfg[i*8 +: 8]}, {24'd0, mview(i)});
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    w(Q/2); sda_m = 1'b0; w(Q/2); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  // sends a byte, returns ack bit; optional model write at the byte's landing point
  task automatic send(logic [7:0] b, bit upd, int idx, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(Q/2); sda_m = b[i]; w(Q/2); scl = 1'b1; w(Q);
      if (i == 0) settle = 1'b1;
      scl = 1'b0;
    end
    w(Q/2); sda_m = 1'b1; w(Q/2);
    if (upd) mwrite(idx, b);
    settle = 1'b0;
    scl = 1'b1; w(Q/2); ack = sda_line; w(Q/2); scl = 1'b0;
  endtask

  task automatic recv(bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q/2); b[i] = sda_line; w(Q/2); scl = 1'b0;
    end
    w(Q/2); sda_m = last; w(Q/2); scl = 1'b1; w(Q); scl = 1'b0; w(Q/2); sda_m = 1'b1; w(Q/2);
  endtask

  task automatic wr_xfer(logic [6:0] a, logic [7:0] bytes[$], bit match);
    logic ack;
    i2c_start();
    send({a, 1'b0}, 1'b0, 0, ack);
    chk(match ? "R2_addr_ack" : "R2_addr_nack", {31'd0, ack}, {31'd0, !match});
    foreach (bytes[k]) begin
      send(bytes[k], match && k >= 2, k - 2, ack);
      if (k < 2) chk("R3_hdr_ack", {31'd0, ack}, {31'd0, !match});
      else if (k >= 15) chk("R6_past_end_ack", {31'd0, ack}, {31'd0, !match});
      else chk("R4_data_ack", {31'd0, ack}, {31'd0, !match});
    end
    i2c_stop();
  endtask

  task automatic rd_xfer(int n);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send({ADR, 1'b1}, 1'b0, 0, ack);
    chk("R5_addr_ack", {31'd0, ack}, 32'd0);
    for (int k = 0; k < n; k++) begin
      recv(k == n - 1, b);
      chk(k > 12 ? "R6_read_past" : "R5_read_data", {24'd0, b}, {24'd0, mview(k)});
    end
    i2c_stop();
  endtask

  initial begin
    logic [7:0] q[$];
    for (int i = 0; i < 13; i++) m[i] = 8'h00;
    m[1] = 8'hCF; m[2] = 8'hFF; m[3] = 8'hFF; m[4] = 8'h07; m[5] = 8'h93; m[7] = 8'h40;
    strap_lat = 5'b10110;
    w(5); rst_n = 1'b1; w(3);
    strap = 5'b01001;
    w(3); settle = 1'b0; w(2);
    chk("R1_reg1", {24'd0, cfg[15:8]}, 32'hCF);
    chk("R1_reg5", {24'd0, cfg[47:40]}, 32'h93);
    chk("R8_strap_latched", {24'd0, cfg[39:32]}, 32'hB7);
    chk("R7_id", {16'd0, cfg[103:88]}, 32'h2105);
    rd_xfer(13);

    q = '{8'hA5, 8'h03, 8'h11, 8'h22, 8'h33, 8'h44};
    wr_xfer(ADR, q, 1'b1);
    chk("R4_reg3", {24'd0, cfg[31:24]}, 32'h44);
    rd_xfer(15);

    q = '{8'h00, 8'hFF};
    for (int k = 0; k < 15; k++) q.push_back(8'((k * 37 + 3) & 255));
    wr_xfer(ADR, q, 1'b1);
    chk("R7_id_kept", {16'd0, cfg[103:88]}, 32'h2105);
    chk("R8_strap_kept", {27'd0, cfg[39:35]}, 32'h16);
    rd_xfer(13);

    settle = 1'b1; flag = 1'b1; w(3); flag_d = 1'b1; settle = 1'b0;
    chk("R9_flag", {31'd0, cfg[54]}, 32'd1);
    rd_xfer(7);

    q = '{8'h01, 8'h02, 8'h5A, 8'h5A};
    wr_xfer(7'h12, q, 1'b0);
    q = '{8'h01, 8'h02};
    wr_xfer(ADR, q, 1'b1);
    chk("R3_hdr_only", {24'd0, cfg[7:0]}, {24'd0, mview(0)});
    q = '{8'h77, 8'h88, 8'h01, 8'hC8, 8'h3C, 8'h0F, 8'h00, 8'h00, 8'hFF};
    wr_xfer(ADR, q, 1'b1);
    chk("R9_bit_ro", {24'd0, cfg[55:48]}, 32'hFF);
    rd_xfer(13);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule